// File: doc/BRIEF.md
# Least-Attained-Service Thread Ranker

This block sits in front of a memory request queue and decides which buffered request goes next. It keeps, for every thread, a running count of the memory service that thread has received in the current quantum. A quantum is a fixed run of `QUANTUM` clock cycles. On the last cycle of each quantum it blends that count into a long-term figure for the thread. The blend is an exponentially weighted average whose history weight is alpha = 1 - 2^-`ALPHA_SHIFT`. The counter is then cleared.

On the first cycle of the next quantum, the threads are re-ranked. The thread with the least long-term service gets rank 0, which is the best rank, and the ranking then stays fixed for the whole quantum. Arbitration is purely combinational and uses the registered ranking. A request whose age exceeds a starvation limit beats every other request. Below that, the better thread rank wins, then a row hit, then the greater age.

A three-state machine sequences each quantum. In ACCUM the counters only accumulate. In FOLD, the last cycle of a quantum, the totals are updated and the counters cleared. In RANK, the first cycle of a quantum, the rank register is loaded. The transitions are ACCUM→FOLD when the position counter reaches `QUANTUM-2`, FOLD→RANK unconditionally, and RANK→ACCUM unconditionally. Reset enters ACCUM at position 0.

Top module: `las_ranker`

## Requirements
- R1: After reset, all counters and totals are zero and thread t holds rank t; `rank_vec` bits [t*TID_W +: TID_W] carry the rank of thread t, and 0 is the best rank.
- R2: Each cycle, every thread's quantum counter adds that thread's `svc_inc` field (bits [t*SVC_W +: SVC_W]), saturating at 2^CNT_W-1.
- R3: On the last cycle of each quantum (every QUANTUM cycles from reset), the total becomes total - (total >> ALPHA_SHIFT) + (count >> ALPHA_SHIFT), saturating at 2^TOT_W-1. The count used includes that cycle's increment, and the counter then restarts from zero.
- R4: The ranking computed from the totals takes effect on the first cycle of each quantum and is visible from the second. A thread's rank is the number of threads with a smaller total, plus the number of threads with an equal total and a lower ID.
- R5: The rank vector does not change at any other time.
- R6: A valid request whose age is strictly greater than STARVE_AGE is granted ahead of every request that is not so old.
- R7: Within the same starvation class, the request whose thread has the lower rank number wins.
- R8: With equal starvation class and rank, a request with its row-hit flag set wins.
- R9: Remaining ties go to the greater age, and then to the lower entry index.
- R10: With no valid entry, `grant_valid` is 0 and `grant_idx` is 0; an entry whose valid bit is clear is never granted, whatever its other fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_inc | input | NT*SVC_W | Per-thread service units attained this cycle |
| req_valid | input | NE | Buffer entry holds a request |
| req_tid | input | NE*TID_W | Thread owning each entry |
| req_hit | input | NE | Entry targets the open row |
| req_age | input | NE*AGE_W | Cycles each entry has waited |
| grant_valid | output | 1 | A request is granted this cycle |
| grant_idx | output | IDX_W | Index of the granted entry |
| rank_vec | output | NT*TID_W | Current rank of each thread |

## Verification
Arbitration and the rank reload meet on the first cycle of a quantum. In that cycle the grant must still follow the old ranking, and from the next cycle it must follow the new one. The bench holds two competing requests from differently ranked threads across a quantum boundary. It checks that the winner changes exactly one cycle after the boundary edge. Service increments arriving on the folding cycle also overlap the total update, and a behavioural model compared on every clock judges both overlaps.

// File: rtl/las_pkg.sv
package las_pkg;

    typedef enum logic [1:0] {
        ST_ACCUM = 2'd0,
        ST_FOLD  = 2'd1,
        ST_RANK  = 2'd2
    } las_state_e;

endpackage

// File: rtl/las_service_track.sv
module las_service_track #(
    parameter int NT          = 4,
    parameter int SVC_W       = 4,
    parameter int CNT_W       = 8,
    parameter int TOT_W       = 10,
    parameter int ALPHA_SHIFT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NT*SVC_W-1:0] svc_inc,
    input  logic                fold_en,
    output logic [NT*TOT_W-1:0] totals
);

    localparam int SUM_W = ((CNT_W > TOT_W) ? CNT_W : TOT_W) + 2;
    localparam logic [SUM_W-1:0] TOT_MAX = SUM_W'({TOT_W{1'b1}});

    for (genvar t = 0; t < NT; t++) begin : g_thread
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W:0]   cnt_add;
        logic [CNT_W-1:0] cnt_sat;
        logic [TOT_W-1:0] tot_q;
        logic [TOT_W-1:0] tot_next;
        logic [SUM_W-1:0] blend;

        always_comb begin
            cnt_add = {1'b0, cnt_q} + (CNT_W+1)'(svc_inc[t*SVC_W +: SVC_W]);
            cnt_sat = cnt_add[CNT_W] ? {CNT_W{1'b1}} : cnt_add[CNT_W-1:0];
            // weighted blend: keep (1 - 2^-s) of history, add 2^-s of the new count
            blend   = SUM_W'(tot_q) - SUM_W'(tot_q >> ALPHA_SHIFT)
                    + SUM_W'(cnt_sat >> ALPHA_SHIFT);
            tot_next = (blend > TOT_MAX) ? {TOT_W{1'b1}} : blend[TOT_W-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
                tot_q <= '0;
            end else if (fold_en) begin
                tot_q <= tot_next;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_sat;
            end
        end

        assign totals[t*TOT_W +: TOT_W] = tot_q;
    end

endmodule

// File: rtl/las_rank_sort.sv
module las_rank_sort #(
    parameter int NT    = 4,
    parameter int TOT_W = 10,
    parameter int TID_W = 2
) (
    input  logic [NT*TOT_W-1:0] totals,
    output logic [NT*TID_W-1:0] ranks
);

    for (genvar t = 0; t < NT; t++) begin : g_rank
        logic [TID_W-1:0] below;

        always_comb begin
            below = '0;
            for (int u = 0; u < NT; u++) begin
                if (u != t) begin
                    if ((totals[u*TOT_W +: TOT_W] < totals[t*TOT_W +: TOT_W]) ||
                        ((totals[u*TOT_W +: TOT_W] == totals[t*TOT_W +: TOT_W]) && (u < t))) begin
                        below = below + TID_W'(1);
                    end
                end
            end
        end

        assign ranks[t*TID_W +: TID_W] = below;
    end

endmodule

// File: rtl/las_arbiter.sv
module las_arbiter #(
    parameter int NT         = 4,
    parameter int NE         = 8,
    parameter int TID_W      = 2,
    parameter int IDX_W      = 3,
    parameter int AGE_W      = 8,
    parameter int STARVE_AGE = 200
) (
    input  logic [NE-1:0]       req_valid,
    input  logic [NE*TID_W-1:0] req_tid,
    input  logic [NE-1:0]       req_hit,
    input  logic [NE*AGE_W-1:0] req_age,
    input  logic [NT*TID_W-1:0] rank_vec,
    output logic                grant_valid,
    output logic [IDX_W-1:0]    grant_idx
);

    localparam int KEY_W = 2 + TID_W + AGE_W;
    localparam logic [AGE_W-1:0] STARVE_LIM = AGE_W'(STARVE_AGE);

    logic [KEY_W-1:0] key [NE];

    for (genvar e = 0; e < NE; e++) begin : g_key
        logic [TID_W-1:0] tid;
        logic [AGE_W-1:0] age;
        logic [TID_W-1:0] trank;
        logic             starved;

        assign tid     = req_tid[e*TID_W +: TID_W];
        assign age     = req_age[e*AGE_W +: AGE_W];
        assign trank   = rank_vec[tid*TID_W +: TID_W];
        assign starved = (age > STARVE_LIM);
        // larger key wins: starvation, then best rank, then row hit, then age
        assign key[e]  = {starved, ~trank, req_hit[e], age};
    end

    logic             found;
    logic [KEY_W-1:0] best_key;
    logic [IDX_W-1:0] best_idx;

    always_comb begin
        found    = 1'b0;
        best_key = '0;
        best_idx = '0;
        for (int e = 0; e < NE; e++) begin
            if (req_valid[e] && (!found || (key[e] > best_key))) begin
                found    = 1'b1;
                best_key = key[e];
                best_idx = IDX_W'(e);
            end
        end
    end

    assign grant_valid = found;
    assign grant_idx   = best_idx;

endmodule

// File: rtl/las_ranker.sv
module las_ranker #(
    parameter int NT          = 4,
    parameter int NE          = 8,
    parameter int SVC_W       = 4,
    parameter int CNT_W       = 8,
    parameter int TOT_W       = 10,
    parameter int AGE_W       = 8,
    parameter int QUANTUM     = 32,
    parameter int STARVE_AGE  = 200,
    parameter int ALPHA_SHIFT = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NT*SVC_W-1:0]           svc_inc,
    input  logic [NE-1:0]                 req_valid,
    input  logic [NE*$clog2(NT)-1:0]      req_tid,
    input  logic [NE-1:0]                 req_hit,
    input  logic [NE*AGE_W-1:0]           req_age,
    output logic                          grant_valid,
    output logic [$clog2(NE)-1:0]         grant_idx,
    output logic [NT*$clog2(NT)-1:0]      rank_vec
);

    import las_pkg::*;

    localparam int TID_W = $clog2(NT);
    localparam int IDX_W = $clog2(NE);
    localparam int QP_W  = $clog2(QUANTUM);
    localparam logic [QP_W-1:0] QP_LAST = QP_W'(QUANTUM - 1);
    localparam logic [QP_W-1:0] QP_PRE  = QP_W'(QUANTUM - 2);

    las_state_e       state_q, state_d;
    logic [QP_W-1:0]  qpos_q;
    logic             fold_en;
    logic             rank_load;

    logic [NT*TOT_W-1:0] totals;
    logic [NT*TID_W-1:0] rank_next;
    logic [NT*TID_W-1:0] rank_q;

    // state register and quantum position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACCUM;
            qpos_q  <= '0;
        end else begin
            state_q <= state_d;
            qpos_q  <= (qpos_q == QP_LAST) ? '0 : qpos_q + QP_W'(1);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCUM: if (qpos_q == QP_PRE) state_d = ST_FOLD;
            ST_FOLD:  state_d = ST_RANK;
            ST_RANK:  state_d = ST_ACCUM;
            default:  state_d = ST_ACCUM;
        endcase
    end

    // state outputs
    always_comb begin
        fold_en   = 1'b0;
        rank_load = 1'b0;
        unique case (state_q)
            ST_ACCUM: ;
            ST_FOLD:  fold_en   = 1'b1;
            ST_RANK:  rank_load = 1'b1;
            default:  ;
        endcase
    end

    las_service_track #(
        .NT(NT), .SVC_W(SVC_W), .CNT_W(CNT_W), .TOT_W(TOT_W), .ALPHA_SHIFT(ALPHA_SHIFT)
    ) i_track (
        .clk(clk), .rst_n(rst_n), .svc_inc(svc_inc), .fold_en(fold_en), .totals(totals)
    );

    las_rank_sort #(
        .NT(NT), .TOT_W(TOT_W), .TID_W(TID_W)
    ) i_sort (
        .totals(totals), .ranks(rank_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) begin
                rank_q[t*TID_W +: TID_W] <= TID_W'(t);
            end
        end else if (rank_load) begin
            rank_q <= rank_next;
        end
    end

    assign rank_vec = rank_q;

    las_arbiter #(
        .NT(NT), .NE(NE), .TID_W(TID_W), .IDX_W(IDX_W),
        .AGE_W(AGE_W), .STARVE_AGE(STARVE_AGE)
    ) i_arb (
        .req_valid(req_valid), .req_tid(req_tid), .req_hit(req_hit),
        .req_age(req_age), .rank_vec(rank_q),
        .grant_valid(grant_valid), .grant_idx(grant_idx)
    );

endmodule

// File: rtl/las_ranker_chk.sv
module las_ranker_chk #(
    parameter int NT         = 4,
    parameter int NE         = 8,
    parameter int AGE_W      = 8,
    parameter int STARVE_AGE = 200
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NE-1:0]              req_valid,
    input logic [NE*AGE_W-1:0]        req_age,
    input logic [NT*$clog2(NT)-1:0]   rank_vec,
    input logic                       grant_valid,
    input logic [$clog2(NE)-1:0]      grant_idx,
    input las_pkg::las_state_e        state_q
);

    localparam int TID_W = $clog2(NT);
    localparam logic [AGE_W-1:0] STARVE_LIM = AGE_W'(STARVE_AGE);

    logic [NT-1:0] occ;
    logic          any_starved;

    always_comb begin
        occ = '0;
        for (int t = 0; t < NT; t++) begin
            occ[rank_vec[t*TID_W +: TID_W]] = 1'b1;
        end
    end

    always_comb begin
        any_starved = 1'b0;
        for (int e = 0; e < NE; e++) begin
            if (req_valid[e] && (req_age[e*AGE_W +: AGE_W] > STARVE_LIM)) any_starved = 1'b1;
        end
    end

    p_rank_perm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(occ) == NT);

    p_rank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != las_pkg::ST_RANK) |-> $stable(rank_vec));

    p_fold_then_rank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == las_pkg::ST_FOLD) |=> (state_q == las_pkg::ST_RANK));

    p_starved_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && any_starved) |-> (req_age[grant_idx*AGE_W +: AGE_W] > STARVE_LIM));

    p_grant_real_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> req_valid[grant_idx]);

    p_no_req_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid == '0) |-> !grant_valid);

endmodule

bind las_ranker las_ranker_chk #(
    .NT(NT), .NE(NE), .AGE_W(AGE_W), .STARVE_AGE(STARVE_AGE)
) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_age(req_age),
    .rank_vec(rank_vec), .grant_valid(grant_valid), .grant_idx(grant_idx),
    .state_q(state_q)
);

// File: tb/test_las_ranker.sv
module test_las_ranker;

    localparam int CLK_PERIOD  = 10;
    localparam int NT          = 4;
    localparam int NE          = 8;
    localparam int SVC_W       = 4;
    localparam int CNT_W       = 8;
    localparam int TOT_W       = 10;
    localparam int AGE_W       = 8;
    localparam int QUANTUM     = 32;
    localparam int STARVE_AGE  = 200;
    localparam int ALPHA_SHIFT = 3;
    localparam int TID_W       = $clog2(NT);
    localparam int IDX_W       = $clog2(NE);
    localparam int CNT_MAX     = (1 << CNT_W) - 1;
    localparam int TOT_MAX     = (1 << TOT_W) - 1;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NT*SVC_W-1:0]   svc_inc = '0;
    logic [NE-1:0]         req_valid = '0;
    logic [NE*TID_W-1:0]   req_tid = '0;
    logic [NE-1:0]         req_hit = '0;
    logic [NE*AGE_W-1:0]   req_age = '0;
    logic                  grant_valid;
    logic [IDX_W-1:0]      grant_idx;
    logic [NT*TID_W-1:0]   rank_vec;

    las_ranker #(
        .NT(NT), .NE(NE), .SVC_W(SVC_W), .CNT_W(CNT_W), .TOT_W(TOT_W),
        .AGE_W(AGE_W), .QUANTUM(QUANTUM), .STARVE_AGE(STARVE_AGE), .ALPHA_SHIFT(ALPHA_SHIFT)
    ) i_las_ranker (
        .clk(clk), .rst_n(rst_n), .svc_inc(svc_inc), .req_valid(req_valid),
        .req_tid(req_tid), .req_hit(req_hit), .req_age(req_age),
        .grant_valid(grant_valid), .grant_idx(grant_idx), .rank_vec(rank_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_err    = 0;
    bit    done     = 1'b0;
    bit    chk_on   = 1'b0;
    string cur_req  = "R10";

    // behavioural reference state
    int m_cnt  [NT];
    int m_tot  [NT];
    int m_rank [NT];
    int k = 0;
    bit m_loaded = 1'b0;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    function automatic int inc_of(int t);
        return int'(svc_inc[t*SVC_W +: SVC_W]);
    endfunction

    always @(posedge clk) begin
        int pos, c, tt, p;
        int order[$];
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) begin
                m_cnt[t] = 0; m_tot[t] = 0; m_rank[t] = t;
            end
            k = 0;
            m_loaded = 1'b0;
        end else begin
            pos = k % QUANTUM;
            m_loaded = 1'b0;
            if (pos == 0) begin
                order = {};
                for (int t = 0; t < NT; t++) begin
                    p = 0;
                    while (p < order.size() && (m_tot[order[p]] < m_tot[t] ||
                           (m_tot[order[p]] == m_tot[t] && order[p] < t))) p++;
                    order.insert(p, t);
                end
                for (int i = 0; i < NT; i++) m_rank[order[i]] = i;
                m_loaded = 1'b1;
            end
            for (int t = 0; t < NT; t++) begin
                c = m_cnt[t] + inc_of(t);
                if (c > CNT_MAX) c = CNT_MAX;
                if (pos == QUANTUM - 1) begin
                    tt = m_tot[t] - (m_tot[t] >> ALPHA_SHIFT) + (c >> ALPHA_SHIFT);
                    if (tt > TOT_MAX) tt = TOT_MAX;
                    m_tot[t] = tt;
                    m_cnt[t] = 0;
                end else begin
                    m_cnt[t] = c;
                end
            end
            k++;
        end
    end

    function automatic void model_grant(output bit v, output int idx);
        int  ae, ab, re, rb;
        bit  se, sb, better;
        v = 1'b0; idx = 0;
        for (int e = 0; e < NE; e++) begin
            if (req_valid[e]) begin
                if (!v) begin
                    v = 1'b1; idx = e;
                end else begin
                    ae = int'(req_age[e*AGE_W +: AGE_W]);
                    ab = int'(req_age[idx*AGE_W +: AGE_W]);
                    re = m_rank[int'(req_tid[e*TID_W +: TID_W])];
                    rb = m_rank[int'(req_tid[idx*TID_W +: TID_W])];
                    se = (ae > STARVE_AGE);
                    sb = (ab > STARVE_AGE);
                    if (se != sb)                      better = se;
                    else if (re != rb)                 better = (re < rb);
                    else if (req_hit[e] != req_hit[idx]) better = req_hit[e];
                    else                               better = (ae > ab);
                    if (better) idx = e;
                end
            end
        end
    endfunction

    function automatic int rank_of(int t);
        return int'(rank_vec[t*TID_W +: TID_W]);
    endfunction

    // every-cycle comparison against the model
    always @(negedge clk) begin
        bit v;
        int idx;
        logic [NT*TID_W-1:0] exp_vec;
        if (chk_on && !done) begin
            for (int t = 0; t < NT; t++) exp_vec[t*TID_W +: TID_W] = TID_W'(m_rank[t]);
            check(rank_vec == exp_vec, m_loaded ? "R4" : "R5", "rank vector",
                  int'(rank_vec), int'(exp_vec));
            model_grant(v, idx);
            check(grant_valid == v, cur_req, "grant_valid", int'(grant_valid), int'(v));
            check(int'(grant_idx) == (v ? idx : 0), cur_req, "grant_idx", int'(grant_idx), v ? idx : 0);
        end
    end

    task automatic set_inc(int t, int v);
        svc_inc[t*SVC_W +: SVC_W] = SVC_W'(v);
    endtask

    task automatic set_req(int e, bit v, int tid, bit hit, int age);
        req_valid[e] = v;
        req_tid[e*TID_W +: TID_W] = TID_W'(tid);
        req_hit[e] = hit;
        req_age[e*AGE_W +: AGE_W] = AGE_W'(age);
    endtask

    task automatic clear_reqs();
        req_valid = '0; req_tid = '0; req_hit = '0; req_age = '0;
    endtask

    task automatic wait_k(int n);
        do @(negedge clk); while (k < n);
    endtask

    task automatic expect_ranks(string tag, int r0, int r1, int r2, int r3);
        check(rank_of(0) == r0, tag, "rank of thread 0", rank_of(0), r0);
        check(rank_of(1) == r1, tag, "rank of thread 1", rank_of(1), r1);
        check(rank_of(2) == r2, tag, "rank of thread 2", rank_of(2), r2);
        check(rank_of(3) == r3, tag, "rank of thread 3", rank_of(3), r3);
    endtask

    task automatic expect_grant(string tag, bit v, int idx);
        check(grant_valid == v, tag, "grant_valid", int'(grant_valid), int'(v));
        check(int'(grant_idx) == idx, tag, "grant_idx", int'(grant_idx), idx);
    endtask

    task automatic step_pattern(string tag, int n);
        cur_req = tag;
        wait_k(n);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // quantum 1 increments: thread 0 and 1 both saturate the counter (R2)
        set_inc(0, 8); set_inc(1, 15); set_inc(2, 0); set_inc(3, 0);
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        chk_on = 1'b1;
        cur_req = "R10";

        wait_k(1);
        expect_ranks("R1", 0, 1, 2, 3);
        expect_grant("R10", 1'b0, 0);

        wait_k(32);
        #1 set_inc(0, 0); set_inc(1, 0); set_inc(2, 3); set_inc(3, 1);

        wait_k(33);
        // both saturated counts fold to 31, tie broken by thread ID
        expect_ranks("R2", 2, 3, 0, 1);

        #1 clear_reqs(); set_req(0, 1, 1, 1, 50); set_req(1, 1, 2, 0, 10);
        step_pattern("R7", 34);
        expect_grant("R7", 1'b1, 1);

        #1 clear_reqs(); set_req(2, 1, 0, 0, 90); set_req(5, 1, 0, 1, 5);
        step_pattern("R8", 35);
        expect_grant("R8", 1'b1, 5);

        #1 clear_reqs(); set_req(3, 1, 3, 1, 40); set_req(6, 1, 3, 1, 41);
        step_pattern("R9", 36);
        expect_grant("R9", 1'b1, 6);

        #1 clear_reqs(); set_req(1, 1, 3, 0, 7); set_req(4, 1, 3, 0, 7);
        step_pattern("R9", 37);
        expect_grant("R9", 1'b1, 1);

        #1 clear_reqs(); set_req(0, 1, 2, 1, 199); set_req(7, 1, 1, 0, 201);
        step_pattern("R6", 38);
        expect_grant("R6", 1'b1, 7);

        #1 clear_reqs(); set_req(0, 1, 1, 1, 200); set_req(1, 1, 0, 0, 10);
        step_pattern("R6", 39);
        expect_grant("R6", 1'b1, 1);

        #1 clear_reqs(); set_req(2, 1, 1, 0, 250); set_req(5, 1, 2, 0, 210);
        step_pattern("R6", 40);
        expect_grant("R6", 1'b1, 5);

        #1 clear_reqs();
        req_tid = '1; req_age = '1; req_hit = '1;
        step_pattern("R10", 41);
        expect_grant("R10", 1'b0, 0);

        #1 clear_reqs(); set_req(3, 0, 2, 1, 255); set_req(6, 1, 1, 0, 1);
        step_pattern("R10", 42);
        expect_grant("R10", 1'b1, 6);

        #1 clear_reqs();
        cur_req = "R10";
        wait_k(45);
        expect_ranks("R5", 2, 3, 0, 1);

        wait_k(63);
        #1 clear_reqs(); set_req(0, 1, 3, 0, 20); set_req(1, 1, 2, 0, 20);
        cur_req = "R4";

        wait_k(64);
        // reload cycle: old ranking still drives the grant
        expect_grant("R4", 1'b1, 1);
        #1 set_inc(0, 0); set_inc(1, 0); set_inc(2, 0); set_inc(3, 0);

        wait_k(65);
        expect_grant("R4", 1'b1, 0);
        // totals 28, 28, 12, 4 after the weighted fold
        expect_ranks("R3", 2, 3, 1, 0);

        // mixed traffic over several quanta, compared each cycle
        cur_req = "R7";
        for (int i = 0; i < 160; i++) begin
            #1;
            for (int t = 0; t < NT; t++) set_inc(t, int'($urandom_range(15, 0)));
            for (int e = 0; e < NE; e++)
                set_req(e, bit'($urandom_range(1, 0)), int'($urandom_range(NT-1, 0)),
                        bit'($urandom_range(1, 0)), int'($urandom_range(255, 150)));
            @(negedge clk);
        end

        finish_run();
    end

endmodule